// File: doc/BRIEF.md
# Channel-Sequenced Address-Event Readout Controller

This block drains the binary activations of a two-dimensional array of convolution kernels through an address-event stream. A load strobe copies a full snapshot of activations into a hold buffer at every kernel site. The array that produced the snapshot is then free to start its next reset and accumulate window while the readout is still running. The controller looks at one output channel at a time, beginning with channel 0. For the selected channel, every kernel site whose held bit is set drives the request line of its row.

A row arbiter serves requesting rows in ascending order with a four-phase request/acknowledge handshake. While its row is acknowledged, a kernel drives its column request line. The column emitter captures all of the row's column requests in one cycle and returns column acknowledges. The kernels then clear their bits, so the row request and both acknowledges fall. The captured events leave one per accepted transfer on a valid/ready port, in ascending column order. Each event is one word holding the channel index, the row (y) and the column (x). The word has no polarity bit. After the last channel has been scanned and nothing is pending, the block raises a single-cycle done pulse.

Top module: `aer_chan_readout`

## Requirements
- R1: A load pulse while the block is idle copies `act_in` into the hold buffer and starts a readout. A load pulse while a readout is in progress has no effect. Bit `(ch*ROWS + y)*COLS + x` of `act_in` is the activation of kernel (y, x) in channel ch.
- R2: Channels are read strictly one after another, from 0 up to CHANS-1. Every event of a lower channel leaves before any event of a higher channel. Each set bit produces exactly one event.
- R3: Within a channel, rows that request at the same time are granted in ascending y order. A row's events all leave before the next row is granted.
- R4: Within a row, events leave in ascending x order.
- R5: The event word is `{ch, y, x}`. x occupies the least significant bits, y is above x, and the channel index is in the most significant bits. Each field is ceil(log2) of its count wide, with a minimum of 1.
- R6: While `ev_valid` is high and `ev_ready` is low, `ev_valid` stays high and `ev_data` does not change.
- R7: Row acknowledges are one-hot or zero. An acknowledge is released in the cycle after its row request falls. Column acknowledges are only present while a row is acknowledged.
- R8: `done` is a one-cycle pulse, raised after the last channel has been scanned with no request pending and no event left to send.
- R9: A snapshot with no set bit produces no event and raises `done` within CHANS+2 cycles of the load.
- R10: After a load, changes on `act_in` do not affect the events of that readout.
- R11: After reset, `ev_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| act_load | input | 1 | Snapshot strobe, accepted only when idle |
| act_in | input | CHANS*ROWS*COLS | Activation snapshot, channel-major, then row, then column |
| ev_valid | output | 1 | An event word is available |
| ev_ready | input | 1 | The consumer accepts the event word |
| ev_data | output | C_W+Y_W+X_W | Event word {channel, y, x} |
| done | output | 1 | One-cycle pulse when the readout is complete |

## Verification
Some rules are checked by assertions on every cycle:
- the row acknowledge is one-hot;
- an acknowledge is released after its request falls, and a column acknowledge never appears without a row acknowledge;
- the arbiter grants the lowest requesting row;
- the channel index only steps by one;
- x ascends between consecutive events of one row;
- the event word is held during a stall;
- the done pulse only occurs with no request pending.

Other behaviour is visible only through the bench's scenarios:
- the full event sequence across channels;
- that every held bit comes out exactly once;
- the exact word encoding;
- that a load during a readout, and edits to `act_in` after a load, leave the stream unchanged;
- the latency of `done` on an empty snapshot.

// File: rtl/aer_rd_pkg.sv
package aer_rd_pkg;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_ACK  = 1'b1
  } arb_state_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_SCAN = 1'b1
  } seq_state_e;

endpackage

// File: rtl/aer_kernel_site.sv
module aer_kernel_site #(
  parameter int CHANS = 3,
  parameter int C_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CHANS-1:0] act_bits,
  input  logic [C_W-1:0]   ch_sel,
  input  logic             row_ack,
  input  logic             col_ack,
  output logic             row_req,
  output logic             col_req
);

  logic [CHANS-1:0] held_q, held_n;
  logic             sel_bit;

  // Shared request logic: one path serves every channel of this site
  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < CHANS; i++) begin
      if (ch_sel == C_W'(i)) sel_bit = held_q[i];
    end
  end

  assign row_req = sel_bit;
  assign col_req = sel_bit & row_ack;

  always_comb begin
    held_n = held_q;
    if (load_en) begin
      held_n = act_bits;
    end else if (row_ack && col_ack) begin
      for (int i = 0; i < CHANS; i++) begin
        if (ch_sel == C_W'(i)) held_n[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_n;
  end

endmodule

// File: rtl/aer_row_arbiter.sv
module aer_row_arbiter
  import aer_rd_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int Y_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] row_req,
  input  logic            allow,
  output logic [ROWS-1:0] row_ack,
  output logic [Y_W-1:0]  grant_y,
  output logic            acked,
  output logic            idle
);

  arb_state_e      st_q, st_n;
  logic [ROWS-1:0] ack_q, ack_n;
  logic [Y_W-1:0]  y_q, y_n;
  logic [ROWS-1:0] low_oh;
  logic [Y_W-1:0]  low_y;

  // Fixed priority: lowest row index wins
  always_comb begin
    low_oh = '0;
    low_y  = '0;
    for (int i = ROWS-1; i >= 0; i--) begin
      if (row_req[i]) begin
        low_oh    = '0;
        low_oh[i] = 1'b1;
        low_y     = Y_W'(i);
      end
    end
  end

  always_comb begin
    st_n  = st_q;
    ack_n = ack_q;
    y_n   = y_q;
    case (st_q)
      ARB_IDLE: begin
        if ((|row_req) && allow) begin
          ack_n = low_oh;
          y_n   = low_y;
          st_n  = ARB_ACK;
        end
      end
      ARB_ACK: begin
        if (!(|(row_req & ack_q))) begin
          ack_n = '0;
          st_n  = ARB_IDLE;
        end
      end
      default: st_n = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ARB_IDLE;
      ack_q <= '0;
      y_q   <= '0;
    end else begin
      st_q  <= st_n;
      ack_q <= ack_n;
      y_q   <= y_n;
    end
  end

  assign row_ack = ack_q;
  assign grant_y = y_q;
  assign acked   = (st_q == ARB_ACK);
  assign idle    = (st_q == ARB_IDLE);

  p_ack_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_ack));

  p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|row_ack) && !(|(row_ack & row_req))) |=> (row_ack == '0));

  p_grant_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && (|row_req) && allow) |=> (row_ack == ($past(row_req) & (~$past(row_req) + 1'b1))));

endmodule

// File: rtl/aer_col_emitter.sv
module aer_col_emitter #(
  parameter int COLS = 4,
  parameter int X_W  = 2,
  parameter int Y_W  = 2,
  parameter int C_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acked,
  input  logic [Y_W-1:0]         grant_y,
  input  logic [C_W-1:0]         ch_sel,
  input  logic [COLS-1:0]        col_req,
  output logic [COLS-1:0]        col_ack,
  output logic                   empty,
  output logic                   ev_valid,
  input  logic                   ev_ready,
  output logic [C_W+Y_W+X_W-1:0] ev_data
);

  logic [COLS-1:0] pend_q, pend_n;
  logic [COLS-1:0] cack_q, cack_n;
  logic            taken_q, taken_n;
  logic [Y_W-1:0]  y_q, y_n;
  logic [COLS-1:0] low_oh;
  logic [X_W-1:0]  low_x;
  logic            latch, pop;

  always_comb begin
    low_oh = '0;
    low_x  = '0;
    for (int i = COLS-1; i >= 0; i--) begin
      if (pend_q[i]) begin
        low_oh    = '0;
        low_oh[i] = 1'b1;
        low_x     = X_W'(i);
      end
    end
  end

  assign latch = acked && !taken_q;
  assign pop   = ev_valid && ev_ready;

  always_comb begin
    pend_n  = pend_q;
    cack_n  = cack_q & col_req;
    y_n     = y_q;
    taken_n = acked ? (taken_q | latch) : 1'b0;
    if (pop) pend_n = pend_q & ~low_oh;
    if (latch) begin
      pend_n = col_req;
      cack_n = col_req;
      y_n    = grant_y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      cack_q  <= '0;
      taken_q <= 1'b0;
      y_q     <= '0;
    end else begin
      pend_q  <= pend_n;
      cack_q  <= cack_n;
      taken_q <= taken_n;
      y_q     <= y_n;
    end
  end

  assign col_ack  = cack_q;
  assign empty    = (pend_q == '0);
  assign ev_valid = !empty;
  assign ev_data  = {ch_sel, y_q, low_x};

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_data)));

  p_x_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && (|(pend_q & ~low_oh))) |=> (ev_data[X_W-1:0] > $past(ev_data[X_W-1:0])));

endmodule

// File: rtl/aer_chan_readout.sv
module aer_chan_readout
  import aer_rd_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int CHANS = 3,
  localparam int X_W  = (COLS  > 1) ? $clog2(COLS)  : 1,
  localparam int Y_W  = (ROWS  > 1) ? $clog2(ROWS)  : 1,
  localparam int C_W  = (CHANS > 1) ? $clog2(CHANS) : 1,
  localparam int D_W  = C_W + Y_W + X_W,
  localparam int A_W  = CHANS * ROWS * COLS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           act_load,
  input  logic [A_W-1:0] act_in,
  output logic           ev_valid,
  input  logic           ev_ready,
  output logic [D_W-1:0] ev_data,
  output logic           done
);

  seq_state_e      seq_q, seq_n;
  logic [C_W-1:0]  ch_q, ch_n;
  logic            done_q, done_n;
  logic            load_en;
  logic [ROWS-1:0] row_req;
  logic [COLS-1:0] col_req;
  logic [ROWS-1:0] row_ack;
  logic [COLS-1:0] col_ack;
  logic [ROWS-1:0][COLS-1:0] site_rreq, site_creq;
  logic [Y_W-1:0]  grant_y;
  logic            acked, arb_idle, emit_empty, quiet;

  assign load_en = act_load && (seq_q == SEQ_IDLE);

  for (genvar gy = 0; gy < ROWS; gy++) begin : g_row
    for (genvar gx = 0; gx < COLS; gx++) begin : g_col
      logic [CHANS-1:0] bits;
      for (genvar gc = 0; gc < CHANS; gc++) begin : g_ch
        assign bits[gc] = act_in[(gc*ROWS + gy)*COLS + gx];
      end
      aer_kernel_site #(.CHANS(CHANS), .C_W(C_W)) site_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .act_bits(bits),
        .ch_sel  (ch_q),
        .row_ack (row_ack[gy]),
        .col_ack (col_ack[gx]),
        .row_req (site_rreq[gy][gx]),
        .col_req (site_creq[gy][gx])
      );
    end
  end

  // Wired-OR of the shared row and column request lines
  always_comb begin
    row_req = '0;
    col_req = '0;
    for (int y = 0; y < ROWS; y++) begin
      for (int x = 0; x < COLS; x++) begin
        row_req[y] = row_req[y] | site_rreq[y][x];
        col_req[x] = col_req[x] | site_creq[y][x];
      end
    end
  end

  aer_row_arbiter #(.ROWS(ROWS), .Y_W(Y_W)) arb_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .row_req(row_req),
    .allow  (emit_empty),
    .row_ack(row_ack),
    .grant_y(grant_y),
    .acked  (acked),
    .idle   (arb_idle)
  );

  aer_col_emitter #(.COLS(COLS), .X_W(X_W), .Y_W(Y_W), .C_W(C_W)) emit_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .acked   (acked),
    .grant_y (grant_y),
    .ch_sel  (ch_q),
    .col_req (col_req),
    .col_ack (col_ack),
    .empty   (emit_empty),
    .ev_valid(ev_valid),
    .ev_ready(ev_ready),
    .ev_data (ev_data)
  );

  assign quiet = !(|row_req) && arb_idle && emit_empty;

  always_comb begin
    seq_n  = seq_q;
    ch_n   = ch_q;
    done_n = 1'b0;
    case (seq_q)
      SEQ_IDLE: begin
        if (act_load) begin
          seq_n = SEQ_SCAN;
          ch_n  = '0;
        end
      end
      SEQ_SCAN: begin
        if (quiet) begin
          if (ch_q == C_W'(CHANS-1)) begin
            seq_n  = SEQ_IDLE;
            done_n = 1'b1;
          end else begin
            ch_n = ch_q + 1'b1;
          end
        end
      end
      default: seq_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SEQ_IDLE;
      ch_q   <= '0;
      done_q <= 1'b0;
    end else begin
      seq_q  <= seq_n;
      ch_q   <= ch_n;
      done_q <= done_n;
    end
  end

  assign done = done_q;

  p_ch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_q != $past(ch_q)) |-> ((ch_q == $past(ch_q) + 1'b1) || (ch_q == '0)));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((row_req == '0) && !ev_valid));

  p_col_ack_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|col_ack) |-> (|row_ack));

endmodule

// File: tb/aer_chan_readout_tb_top.sv
module aer_chan_readout_tb_top;

  localparam int ROWS  = 4;
  localparam int COLS  = 4;
  localparam int CHANS = 3;
  localparam int X_W   = 2;
  localparam int Y_W   = 2;
  localparam int C_W   = 2;
  localparam int D_W   = C_W + Y_W + X_W;
  localparam int A_W   = CHANS * ROWS * COLS;

  logic           clk;
  logic           rst_n;
  logic           act_load;
  logic [A_W-1:0] act_in;
  logic           ev_valid;
  logic           ev_ready;
  logic [D_W-1:0] ev_data;
  logic           done;

  int checks;
  int failures;

  aer_chan_readout #(.ROWS(ROWS), .COLS(COLS), .CHANS(CHANS)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_load(act_load),
    .act_in  (act_in),
    .ev_valid(ev_valid),
    .ev_ready(ev_ready),
    .ev_data (ev_data),
    .done    (done)
  );

  initial clk = 1'b0;
  always #2.5ns clk = ~clk;

  initial begin
    #900us;
    failures++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one readout window and compares the event stream with the sorted model
  task automatic run_window(input logic [A_W-1:0] pat, input int stall_mode,
                            input bit late_load, input logic [A_W-1:0] late_pat,
                            input string tag, output int done_cyc);
    logic [D_W-1:0] exp_q [0:A_W-1];
    int             exp_n;
    int             got_n;
    bit             hold_chk;
    logic [D_W-1:0] held;
    bit             seen_done;
    exp_n = 0;
    for (int c = 0; c < CHANS; c++)
      for (int y = 0; y < ROWS; y++)
        for (int x = 0; x < COLS; x++)
          if (pat[(c*ROWS + y)*COLS + x]) begin
            exp_q[exp_n] = {C_W'(c), Y_W'(y), X_W'(x)};
            exp_n++;
          end
    @(negedge clk);
    act_in   = pat;
    act_load = 1'b1;
    @(negedge clk);
    act_load = 1'b0;
    act_in   = ~pat;  // R10: source changes after the snapshot
    got_n     = 0;
    hold_chk  = 1'b0;
    held      = '0;
    seen_done = 1'b0;
    done_cyc  = -1;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (cyc > 0) @(negedge clk);
      case (stall_mode)
        1:       ev_ready = cyc[0];
        2:       ev_ready = (cyc[1:0] == 2'b11);
        default: ev_ready = 1'b1;
      endcase
      if (late_load && cyc == 3) begin
        act_in   = late_pat;
        act_load = 1'b1;
      end
      if (late_load && cyc == 4) act_load = 1'b0;
      if (hold_chk)
        check(ev_valid && (ev_data == held), {tag, " R6 stall hold"}, {ev_valid, ev_data}, {1'b1, held});
      hold_chk = ev_valid && !ev_ready;
      held     = ev_data;
      if (ev_valid && ev_ready) begin
        if (got_n < exp_n)
          check(ev_data == exp_q[got_n], {tag, " R2 R3 R4 event order"}, ev_data, exp_q[got_n]);
        got_n++;
      end
      if (done) begin
        seen_done = 1'b1;
        done_cyc  = cyc;
        break;
      end
    end
    check(seen_done, {tag, " R8 done seen"}, seen_done, 1);
    check(got_n == exp_n, {tag, " R2 event count"}, got_n, exp_n);
    @(negedge clk);
    check(!done && !ev_valid, {tag, " R8 done single pulse"}, {done, ev_valid}, 0);
    ev_ready = 1'b0;
  endtask

  task automatic t_reset();
    check(!ev_valid && !done, "R11 reset state", {ev_valid, done}, 0);
  endtask

  task automatic t_format();
    logic [A_W-1:0] p;
    int             dc;
    p = '0;
    p[(2*ROWS + 1)*COLS + 3] = 1'b1;
    @(negedge clk);
    act_in = p; act_load = 1'b1; ev_ready = 1'b0;
    @(negedge clk);
    act_load = 1'b0;
    for (int i = 0; i < 20 && !ev_valid; i++) @(negedge clk);
    // R5: ch=2, y=1, x=3 -> 10_01_11
    check(ev_valid && ev_data == 6'h27, "R5 word format", ev_data, 6'h27);
    ev_ready = 1'b1;
    @(negedge clk);
    ev_ready = 1'b0;
    for (int i = 0; i < 20 && !done; i++) @(negedge clk);
    check(done, "R8 done after single event", done, 1);
    @(negedge clk);
    dc = 0;
  endtask

  task automatic t_rows();
    logic [A_W-1:0] p;
    int             dc;
    p = '0;
    p[(0*ROWS + 3)*COLS + 0] = 1'b1;
    p[(0*ROWS + 3)*COLS + 2] = 1'b1;
    p[(0*ROWS + 0)*COLS + 3] = 1'b1;
    p[(0*ROWS + 0)*COLS + 1] = 1'b1;
    p[(0*ROWS + 2)*COLS + 0] = 1'b1;
    p[(0*ROWS + 2)*COLS + 1] = 1'b1;
    p[(0*ROWS + 2)*COLS + 2] = 1'b1;
    p[(0*ROWS + 2)*COLS + 3] = 1'b1;
    run_window(p, 0, 1'b0, '0, "rows R3 R4", dc);
  endtask

  task automatic t_dense_stall();
    int dc;
    run_window(48'hA5C3_0F96_3C71, 1, 1'b0, '0, "dense R2 R6", dc);
    run_window({A_W{1'b1}}, 2, 1'b0, '0, "full R2 R6", dc);
  endtask

  task automatic t_empty();
    int dc;
    run_window('0, 0, 1'b0, '0, "empty R9", dc);
    check(dc >= 0 && dc <= CHANS + 2, "R9 empty done latency", dc, CHANS + 2);
  endtask

  task automatic t_busy_load();
    int dc;
    // R1: second load during the readout is ignored; R10: act_in edits ignored
    run_window(48'h0000_8001_0240, 2, 1'b1, 48'hFFFF_FFFF_FFFF, "busy load R1 R10", dc);
    repeat (4) @(negedge clk);
    check(!ev_valid && !done, "R1 no readout from ignored load", {ev_valid, done}, 0);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    rst_n    = 1'b0;
    act_load = 1'b0;
    act_in   = '0;
    ev_ready = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_format();
    t_rows();
    t_dense_stall();
    t_empty();
    t_busy_load();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule